// File: doc/BRIEF.md
# Receive FIFO Block Pointer Indirect Access Controller

This block sits between a host register bus and two pointer tables of a multi-channel receive FIFO. One table holds, for every channel, the block the receive write engine is currently filling; the host seeds it with a starting block. The other is the linked-list RAM that names, for every block, the block that follows it. The host never addresses the tables directly. It stages a value in a data register, writes a select register carrying the target index and a direction bit, and polls a busy flag. Reads deliver their result into the data register once busy has dropped.

A write-engine port runs beside the host path. Each advance strobe moves the named channel's current pointer one step along the linked list. As a result, a host read of a channel returns the pointer in use at that moment, which may differ from the value the host programmed. When an advance lands in the cycle in which a host access would complete, the host access completes one cycle later.

Top module: `rxq_ptr_indirect`

## Requirements
- R1: A synchronous active-high reset clears busy, all four host registers and every entry of both tables to zero.
- R2: Register map on `host_addr`: 0 is the staged starting-pointer data, 1 is the channel select, 2 is the block-pointer data and 3 is the block select. Data registers hold a 10-bit pointer in bits 9:0 and read zero in bits 15:10. In a select word, bit 15 is busy (read-only), bit 14 is the direction, the index is in bits 9:0 (the channel index uses bits 7:0), and bits 13:10 read zero.
- R3: Writing a select register while idle sets busy from the next cycle. Busy stays high for 2 cycles for a channel-table access and 3 cycles for a linked-list access, then clears.
- R4: A channel-table write (bit 14 = 0) stores the staged starting-pointer data into the entry of the channel in select bits 7:0.
- R5: A channel-table read (bit 14 = 1) loads the staged starting-pointer data register with that channel's current pointer, visible once busy clears.
- R6: A linked-list write stores the block-pointer data at the block in select bits 9:0. A linked-list read loads the block-pointer data register with that entry once busy clears.
- R7: While busy is high, host writes to either select register and to either data register are ignored.
- R8: An advance strobe for a channel replaces its current pointer with the linked-list entry of that pointer. A later host read of the channel returns the advanced value, not the value the host programmed.
- R9: An advance strobe in the completing cycle of a host access holds that access for one more cycle; busy is then high for one cycle longer.
- R10: Any 10-bit value, including 0x3FF, is accepted as a channel's starting pointer, with no check against the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_addr` (combinational) |
| adv_en | input | 1 | Write-engine advance strobe |
| adv_ch | input | 8 | Channel to advance |

## Verification
On every cycle, the assertions check the busy sequencing: busy rises after a start, clears after a completion, and holds through a stalled completion cycle. They also check that the select and data registers stay frozen during an access, that an advance and a table write never coincide, and that an advance loads the linked-list value. Whether each table entry actually holds what the host wrote, whether reads return the right entry, and how long busy lasts as seen at the ports can only be shown by the bench's sweeps. The bench writes and reads back all 1024 blocks and all 256 channels, walks channels along their chains, and times a collision cycle by cycle.

// File: rtl/rxq_ptr_pkg.sv
package rxq_ptr_pkg;
  localparam int REG_W    = 16;
  localparam int DIR_BIT  = 14;
  localparam int BUSY_BIT = 15;

  typedef enum logic [1:0] {
    RA_SPTR_DATA = 2'd0,
    RA_SPTR_SEL  = 2'd1,
    RA_LINK_DATA = 2'd2,
    RA_LINK_SEL  = 2'd3
  } reg_addr_e;

  typedef enum logic {
    TBL_CHAN = 1'b0,
    TBL_LINK = 1'b1
  } tbl_e;

  // Data word: pointer in the low bits, upper bits zero.
  function automatic logic [REG_W-1:0] data_word(input logic [13:0] v);
    return {2'b00, v};
  endfunction

  // Select word: busy on top, direction below it, index in the low field.
  function automatic logic [REG_W-1:0] sel_word(input logic busy, input logic dir,
                                                input logic [13:0] idx);
    return {busy, dir, idx};
  endfunction

  // Access latency for a table.
  function automatic int unsigned lat_of(input logic tbl, input int unsigned chan_lat,
                                         input int unsigned link_lat);
    return tbl ? link_lat : chan_lat;
  endfunction
endpackage

// File: rtl/rxq_host_regs.sv
module rxq_host_regs
  import rxq_ptr_pkg::*;
#(
  parameter int PTR_W = 10,
  parameter int CH_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_we,
  input  logic [1:0]       host_addr,
  input  logic [15:0]      host_wdata,
  output logic [15:0]      host_rdata,
  input  logic             busy,
  input  logic             commit,
  input  logic             cap_en,
  input  logic             cap_tbl,
  input  logic [PTR_W-1:0] cap_val,
  output logic             start,
  output logic             start_tbl,
  output logic             start_rd,
  output logic [PTR_W-1:0] sptr_data,
  output logic [PTR_W-1:0] link_data,
  output logic [CH_W-1:0]  chan_idx,
  output logic [PTR_W-1:0] blk_idx
);
  logic chan_rd;
  logic blk_rd;

  logic idle_we;
  logic wr_sptr_sel, wr_link_sel, wr_sptr_data, wr_link_data;
  logic unused_wbits;

  assign idle_we      = host_we && !busy;
  assign wr_sptr_sel  = idle_we && (host_addr == RA_SPTR_SEL);
  assign wr_link_sel  = idle_we && (host_addr == RA_LINK_SEL);
  assign wr_sptr_data = idle_we && (host_addr == RA_SPTR_DATA);
  assign wr_link_data = idle_we && (host_addr == RA_LINK_DATA);

  assign start     = wr_sptr_sel || wr_link_sel;
  assign start_tbl = wr_link_sel ? TBL_LINK : TBL_CHAN;
  assign start_rd  = host_wdata[DIR_BIT];

  assign unused_wbits = ^{host_wdata[BUSY_BIT], host_wdata[DIR_BIT-1:PTR_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sptr_data <= '0;
      link_data <= '0;
      chan_idx  <= '0;
      blk_idx   <= '0;
      chan_rd   <= 1'b0;
      blk_rd    <= 1'b0;
    end else begin
      if (wr_sptr_data)
        sptr_data <= host_wdata[PTR_W-1:0];
      else if (cap_en && (cap_tbl == TBL_CHAN))
        sptr_data <= cap_val;

      if (wr_link_data)
        link_data <= host_wdata[PTR_W-1:0];
      else if (cap_en && (cap_tbl == TBL_LINK))
        link_data <= cap_val;

      if (wr_sptr_sel) begin
        chan_idx <= host_wdata[CH_W-1:0];
        chan_rd  <= host_wdata[DIR_BIT];
      end
      if (wr_link_sel) begin
        blk_idx <= host_wdata[PTR_W-1:0];
        blk_rd  <= host_wdata[DIR_BIT];
      end
    end
  end

  always_comb begin
    case (host_addr)
      RA_SPTR_DATA: host_rdata = data_word(14'(sptr_data));
      RA_SPTR_SEL:  host_rdata = sel_word(busy, chan_rd, 14'(chan_idx));
      RA_LINK_DATA: host_rdata = data_word(14'(link_data));
      default:      host_rdata = sel_word(busy, blk_rd, 14'(blk_idx));
    endcase
  end

  // R7: data registers are frozen while an access runs, except at its completion.
  p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !commit) |=> ($stable(sptr_data) && $stable(link_data)));

  // R7: select contents do not move during an access.
  p_sel_hold_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(chan_idx) && $stable(blk_idx) && $stable(chan_rd) && $stable(blk_rd)));
endmodule

// File: rtl/rxq_access_seq.sv
module rxq_access_seq
  import rxq_ptr_pkg::*;
#(
  parameter int CHAN_LAT = 2,
  parameter int LINK_LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_tbl,
  input  logic start_rd,
  input  logic stall,
  output logic busy,
  output logic last,
  output logic commit,
  output logic act_tbl,
  output logic act_rd
);
  localparam int MAX_LAT = (CHAN_LAT > LINK_LAT) ? CHAN_LAT : LINK_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] start_cnt;

  assign start_cnt = CNT_W'(lat_of(start_tbl, CHAN_LAT, LINK_LAT));
  assign last      = busy && (cnt == CNT_W'(1));
  assign commit    = last && !stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      act_tbl <= TBL_CHAN;
      act_rd  <= 1'b0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      cnt     <= start_cnt;
      act_tbl <= start_tbl;
      act_rd  <= start_rd;
    end else if (busy) begin
      if (commit) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (!last) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // R3: a start raises busy with the full latency loaded.
  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && cnt == $past(start_cnt)));

  // R3: completion drops busy.
  p_commit_clear_r3: assert property (@(posedge clk) disable iff (rst)
    commit |=> !busy);

  // R3: busy never appears without a start.
  p_idle_stays_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy);

  // R9: a stalled completion cycle repeats.
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (last && stall) |=> last);
endmodule

// File: rtl/rxq_chan_table.sv
module rxq_chan_table #(
  parameter int PTR_W = 10,
  parameter int CH_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [PTR_W-1:0] wr_val,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [PTR_W-1:0] rd_val,
  input  logic             adv,
  input  logic [CH_W-1:0]  adv_ch,
  output logic [PTR_W-1:0] adv_cur,
  input  logic [PTR_W-1:0] adv_next
);
  localparam int NCH = 1 << CH_W;

  logic [PTR_W-1:0] cur_ptr [NCH];

  assign rd_val  = cur_ptr[rd_ch];
  assign adv_cur = cur_ptr[adv_ch];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) cur_ptr[i] <= '0;
    end else begin
      if (wr_en) cur_ptr[wr_ch] <= wr_val;
      if (adv)   cur_ptr[adv_ch] <= adv_next;
    end
  end

  // R9: the stall keeps a host write and an advance apart.
  always_comb begin
    if (!rst) p_no_collide_r9: assert (!(wr_en && adv));
  end

  // R8: an advance loads the successor block.
  p_adv_load_r8: assert property (@(posedge clk) disable iff (rst)
    adv |=> (cur_ptr[$past(adv_ch)] == $past(adv_next)));
endmodule

// File: rtl/rxq_link_ram.sv
module rxq_link_ram #(
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_blk,
  input  logic [PTR_W-1:0] wr_val,
  input  logic [PTR_W-1:0] rd_blk,
  output logic [PTR_W-1:0] rd_val,
  input  logic [PTR_W-1:0] lk_blk,
  output logic [PTR_W-1:0] lk_next
);
  localparam int NBLK = 1 << PTR_W;

  logic [PTR_W-1:0] nxt [NBLK];

  assign rd_val  = nxt[rd_blk];
  assign lk_next = nxt[lk_blk];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBLK; i++) nxt[i] <= '0;
    end else if (wr_en) begin
      nxt[wr_blk] <= wr_val;
    end
  end

  // R6: a committed write lands at the addressed block.
  p_link_write_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (nxt[$past(wr_blk)] == $past(wr_val)));
endmodule

// File: rtl/rxq_ptr_indirect.sv
module rxq_ptr_indirect
  import rxq_ptr_pkg::*;
#(
  parameter int PTR_W    = 10,
  parameter int CH_W     = 8,
  parameter int CHAN_LAT = 2,
  parameter int LINK_LAT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_we,
  input  logic [1:0]      host_addr,
  input  logic [15:0]     host_wdata,
  output logic [15:0]     host_rdata,
  input  logic            adv_en,
  input  logic [CH_W-1:0] adv_ch
);
  logic             start, start_tbl, start_rd;
  logic             busy, last, commit, act_tbl, act_rd;
  logic [PTR_W-1:0] sptr_data, link_data, blk_idx;
  logic [CH_W-1:0]  chan_idx;
  logic [PTR_W-1:0] chan_rd_val, link_rd_val, cap_val;
  logic [PTR_W-1:0] adv_cur, adv_next;
  logic             cap_en, chan_wr, link_wr;

  // Named completion events.
  assign cap_en  = commit && act_rd;
  assign chan_wr = commit && !act_rd && (act_tbl == TBL_CHAN);
  assign link_wr = commit && !act_rd && (act_tbl == TBL_LINK);
  assign cap_val = (act_tbl == TBL_LINK) ? link_rd_val : chan_rd_val;

  rxq_host_regs #(.PTR_W(PTR_W), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy), .commit(commit),
    .cap_en(cap_en), .cap_tbl(act_tbl), .cap_val(cap_val),
    .start(start), .start_tbl(start_tbl), .start_rd(start_rd),
    .sptr_data(sptr_data), .link_data(link_data), .chan_idx(chan_idx), .blk_idx(blk_idx)
  );

  rxq_access_seq #(.CHAN_LAT(CHAN_LAT), .LINK_LAT(LINK_LAT)) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_tbl(start_tbl), .start_rd(start_rd),
    .stall(adv_en), .busy(busy), .last(last), .commit(commit),
    .act_tbl(act_tbl), .act_rd(act_rd)
  );

  rxq_chan_table #(.PTR_W(PTR_W), .CH_W(CH_W)) u_chan (
    .clk(clk), .rst(rst), .wr_en(chan_wr), .wr_ch(chan_idx), .wr_val(sptr_data),
    .rd_ch(chan_idx), .rd_val(chan_rd_val), .adv(adv_en), .adv_ch(adv_ch),
    .adv_cur(adv_cur), .adv_next(adv_next)
  );

  rxq_link_ram #(.PTR_W(PTR_W)) u_link (
    .clk(clk), .rst(rst), .wr_en(link_wr), .wr_blk(blk_idx), .wr_val(link_data),
    .rd_blk(blk_idx), .rd_val(link_rd_val), .lk_blk(adv_cur), .lk_next(adv_next)
  );

  // R7: the register front end never starts a second access while one runs.
  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);

  // R9: an advance in the final cycle postpones completion.
  p_adv_stalls_r9: assert property (@(posedge clk) disable iff (rst)
    (last && adv_en) |-> !commit);

  // R5: a channel read delivers the current pointer.
  p_chan_read_r5: assert property (@(posedge clk) disable iff (rst)
    (cap_en && act_tbl == TBL_CHAN) |=> (sptr_data == $past(chan_rd_val)));
endmodule

// File: tb/rxq_ptr_indirect_tb.sv
module rxq_ptr_indirect_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = 16'd0;
  logic [15:0] host_rdata;
  logic        adv_en = 1'b0;
  logic [7:0]  adv_ch = 8'd0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  logic [9:0] link_m [1024];
  logic [9:0] cur_m  [256];

  rxq_ptr_indirect u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .adv_en(adv_en), .adv_ch(adv_ch)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog: got=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  // Select write, then count the cycles busy is seen high.
  task automatic acc(input logic [1:0] sa, input logic dir, input logic [9:0] idx,
                     output int n);
    @(negedge clk);
    host_addr = sa; host_wdata = {1'b0, dir, 4'b0000, idx}; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0; host_addr = sa; n = 0;
    #1;
    while (host_rdata[15] && n < 20) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic advance(input logic [7:0] c);
    @(negedge clk);
    adv_en = 1'b1; adv_ch = c;
    @(negedge clk);
    adv_en = 1'b0;
    cur_m[c] = link_m[cur_m[c]];
  endtask

  initial begin
    logic [15:0] v;
    int n;
    int lat_bad;
    for (int i = 0; i < 1024; i++) link_m[i] = 10'((i * 37 + 5) & 1023);
    for (int i = 0; i < 256; i++) cur_m[i] = 10'((i * 13 + 7) & 1023);
    cur_m[3] = 10'h3FF;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: every register reads zero after reset.
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk($sformatf("R1 reg%0d after reset", a), v, 16'h0000);
    end
    // R1: tables cleared.
    acc(2'd1, 1'b1, 10'd5, n);
    rd(2'd0, v); chk("R1 channel 5 after reset", v, 16'h0000);
    acc(2'd3, 1'b1, 10'd100, n);
    rd(2'd2, v); chk("R1 block 100 after reset", v, 16'h0000);

    // R2: data register keeps bits 9:0 only.
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); chk("R2 data reg upper bits", v, 16'h03FF);

    // R2/R3: select word during busy: busy=1, dir, index; bits 13:10 zero.
    @(negedge clk);
    host_addr = 2'd3; host_wdata = 16'h7C55; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
    rd(2'd3, v); chk("R2 block select readback while busy", v, 16'hC055);
    repeat (4) @(negedge clk);
    rd(2'd3, v); chk("R2 block select readback idle", v, 16'h4055);

    // R3: latency of each table.
    wr(2'd2, 16'd0);
    acc(2'd3, 1'b0, 10'd0, n);
    chk("R3 link busy cycles", 16'(n), 16'd3);
    acc(2'd1, 1'b0, 10'd0, n);
    chk("R3 chan busy cycles", 16'(n), 16'd2);

    // R6: sweep of the whole linked-list RAM.
    lat_bad = 0;
    for (int b = 0; b < 1024; b++) begin
      wr(2'd2, 16'(link_m[b]));
      acc(2'd3, 1'b0, 10'(b), n);
      if (n != 3) lat_bad++;
    end
    chk("R3 link write latency over sweep", 16'(lat_bad), 16'd0);
    for (int b = 0; b < 1024; b++) begin
      acc(2'd3, 1'b1, 10'(b), n);
      rd(2'd2, v);
      chk($sformatf("R6 block %0d readback", b), v, 16'(link_m[b]));
    end

    // R4/R10: program every channel, including 0x3FF on channel 3.
    for (int c = 0; c < 256; c++) begin
      wr(2'd0, 16'(cur_m[c]));
      acc(2'd1, 1'b0, 10'(c), n);
    end
    for (int c = 0; c < 256; c++) begin
      acc(2'd1, 1'b1, 10'(c), n);
      rd(2'd0, v);
      chk($sformatf("R4 R5 channel %0d readback", c), v, 16'(cur_m[c]));
    end
    acc(2'd1, 1'b1, 10'd3, n);
    rd(2'd0, v); chk("R10 channel 3 holds 0x3FF", v, 16'h03FF);

    // R7: writes during busy are ignored.
    wr(2'd0, 16'h0123);
    @(negedge clk);
    host_addr = 2'd3; host_wdata = 16'h400A; host_we = 1'b1;  // read block 10
    @(negedge clk);
    host_addr = 2'd3; host_wdata = 16'h4014;                  // ignored
    @(negedge clk);
    host_addr = 2'd0; host_wdata = 16'h0155;                  // ignored
    @(negedge clk);
    host_we = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd3, v); chk("R7 block select unchanged", v, 16'h400A);
    rd(2'd2, v); chk("R7 read result of block 10", v, 16'(link_m[10]));
    rd(2'd0, v); chk("R7 start data unchanged", v, 16'h0123);
    @(negedge clk);
    host_addr = 2'd1; host_wdata = 16'h4007; host_we = 1'b1;  // read channel 7
    @(negedge clk);
    host_addr = 2'd2; host_wdata = 16'h02AA;                  // ignored
    @(negedge clk);
    host_we = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd2, v); chk("R7 block data unchanged", v, 16'(link_m[10]));
    rd(2'd0, v); chk("R7 channel 7 read", v, 16'(cur_m[7]));

    // R8: walk channels along their chains.
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 3; s++) begin
        advance(8'(k * 61 + 2));
        acc(2'd1, 1'b1, 10'(k * 61 + 2), n);
        rd(2'd0, v);
        chk($sformatf("R8 channel %0d step %0d", k * 61 + 2, s), v, 16'(cur_m[k * 61 + 2]));
      end
    end
    advance(8'd3);
    acc(2'd1, 1'b1, 10'd3, n);
    rd(2'd0, v); chk("R8 channel 3 differs from programmed", v, 16'(link_m[10'h3FF]));

    // R9: advance in the completing cycle stretches busy by one.
    @(negedge clk);
    host_addr = 2'd1; host_wdata = 16'h4028; host_we = 1'b1;  // read channel 40
    @(negedge clk);
    host_we = 1'b0; n = 0;
    #1 if (host_rdata[15]) n++;
    @(negedge clk);
    adv_en = 1'b1; adv_ch = 8'd40;
    #1 if (host_rdata[15]) n++;
    @(negedge clk);
    adv_en = 1'b0;
    #1 if (host_rdata[15]) n++;
    chk("R9 busy still high after stalled cycle", 16'(host_rdata[15]), 16'd1);
    @(negedge clk);
    #1 if (host_rdata[15]) n++;
    cur_m[40] = link_m[cur_m[40]];
    chk("R9 busy cycles with stall", 16'(n), 16'd3);
    rd(2'd0, v); chk("R9 read sees advanced pointer", v, 16'(cur_m[40]));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule